// File: doc/BRIEF.md
# SPI Slave Transmitter with Replaying Ring Buffer

This block is the transmit half of an SPI slave. A host writes bytes into an eight-slot circular buffer through a write strobe, and the block reports when the buffer is full. An external master selects the slave by pulling chip select low and clocks out one byte per selection on MISO. Inputs use SPI mode 0, and the most significant bit leaves first.

The buffer keeps a read pointer, a write pointer and an occupancy count. Only the count decides whether the buffer is empty. Reading a slot leaves the stored value in place. When the master starts a transfer and unsent data exists, the oldest byte is taken and the read pointer moves on. When nothing is pending, the byte sent is whatever the slot under the read pointer still holds, and the pointer does not move. That slot holds the value written eight writes earlier. It holds zero if fewer than eight writes have happened since reset.

The serial inputs are brought into the system clock domain through two-stage synchronisers. The byte to send is chosen when the synchronised chip select goes low. The system clock must therefore run several times faster than SCLK.

Top module: `spi_ring_tx`

## Requirements
- R1: The buffer has 8 slots. `full` is 1 when 8 unsent bytes are held, and `empty` is 1 when none are held. The two flags are never 1 together.
- R2: Each falling edge of `cs_n` produces exactly one 8-bit frame on `miso`, MSB first. The first bit is valid before the first rising edge of `sclk`. Each later bit changes only after a falling edge of `sclk`. The master samples on rising edges.
- R3: While unsent bytes exist, each frame is the oldest unsent byte, and taking it removes it from the count (first in, first out).
- R4: When the buffer is empty at the start of a transfer, the frame is the byte stored in the slot under the read pointer, and the read pointer does not move. Repeated empty transfers therefore resend the same byte until a new write arrives. After eight or more writes, that byte is the one written eight writes before.
- R5: Reset clears all eight slots to 0x00, so an empty transfer sends 0x00 until that slot has been written.
- R6: A write while `full` is 1 is dropped and leaves the stored bytes untouched. It also sets `overflow`, which stays 1 until reset.
- R7: `underflow_cnt` increments by one on every transfer that starts with the buffer empty, and it saturates at 15.
- R8: `miso` is high impedance whenever `cs_n` is high.
- R9: After reset, `empty`=1, `full`=0, `overflow`=0 and `underflow_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to queue |
| full | output | 1 | Eight unsent bytes held |
| empty | output | 1 | No unsent byte held |
| overflow | output | 1 | Sticky: a write was dropped while full |
| underflow_cnt | output | 4 | Saturating count of transfers that started empty |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master, high impedance when deselected |

## Verification
Some rules are checked on every cycle by in-line assertions:
- `full` and `empty` are never 1 together.
- The read pointer holds still on an empty transfer.
- `overflow` is sticky, and a dropped write leaves the buffer full.
- `underflow_cnt` steps by one and then saturates.
- A select edge loads the chosen byte into the shifter, and one selection gives only one load.

Other behaviour can only be shown by the bench's scenarios:
- The stale data that is replayed, including the byte written eight writes earlier and the zero sent before eight writes.
- The order of bytes on `miso`.
- The high-impedance line between selections.

// File: rtl/spi_ring_pkg.sv
package spi_ring_pkg;
    localparam int RING_DEPTH = 8;
    localparam int FRAME_W    = 8;
    localparam int UCNT_W     = 4;
    localparam int SYNC_W     = 2;
endpackage

// File: rtl/spi_ring_sync.sv
module spi_ring_sync #(
    parameter int             WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/spi_ring_fifo.sv
module spi_ring_fifo #(
    parameter int DEPTH  = spi_ring_pkg::RING_DEPTH,
    parameter int DATA_W = spi_ring_pkg::FRAME_W,
    parameter int UCNT_W = spi_ring_pkg::UCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty,
    output logic              overflow,
    output logic [UCNT_W-1:0] ucnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [UCNT_W-1:0] UCNT_TOP = '1;

    typedef struct packed {
        logic [PTR_W-1:0]  rd;
        logic [PTR_W-1:0]  wr;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [UCNT_W-1:0] ucnt;
    } ring_st_t;

    ring_st_t          st_q, st_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic              accept;
    logic              consume;

    assign accept  = wr_en && (st_q.cnt != CNT_MAX);
    assign consume = take && (st_q.cnt != '0);

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (accept) begin
            mem_d[st_q.wr] = wr_data;
            st_d.wr        = st_q.wr + 1'b1;
        end
        if (wr_en && !accept) begin
            st_d.ovf = 1'b1;
        end
        if (consume) begin
            st_d.rd = st_q.rd + 1'b1;
        end else if (take && (st_q.ucnt != UCNT_TOP)) begin
            st_d.ucnt = st_q.ucnt + 1'b1;
        end
        case ({accept, consume})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign head     = mem_q[st_q.rd];
    assign full     = (st_q.cnt == CNT_MAX);
    assign empty    = (st_q.cnt == '0);
    assign overflow = st_q.ovf;
    assign ucnt     = st_q.ucnt;

    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    p_replay_keeps_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && empty) |=> (st_q.rd == $past(st_q.rd)));
    p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    p_drop_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !take) |=> (full && overflow));
    p_ucnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && empty && (ucnt != UCNT_TOP)) |=> (ucnt == $past(ucnt) + 1'b1));
    p_ucnt_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ucnt == UCNT_TOP) |=> (ucnt == UCNT_TOP));
endmodule

// File: rtl/spi_ring_shifter.sv
module spi_ring_shifter #(
    parameter int DATA_W = spi_ring_pkg::FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic [DATA_W-1:0] frame,
    output logic              load,
    output logic              bit_out
);
    typedef struct packed {
        logic              sclk_prev;
        logic              cs_prev;
        logic [DATA_W-1:0] sh;
    } shift_st_t;

    localparam shift_st_t ST_RESET = '{sclk_prev: 1'b0, cs_prev: 1'b1, sh: '0};

    shift_st_t st_q, st_d;
    logic      sclk_fall;

    assign load      = st_q.cs_prev && !cs_n_s;
    assign sclk_fall = st_q.sclk_prev && !sclk_s && !cs_n_s;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_n_s;
        if (load) begin
            st_d.sh = frame;
        end else if (sclk_fall) begin
            st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign bit_out = st_q.sh[DATA_W-1];

    p_load_captures_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.sh == $past(frame)));
    p_single_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/spi_ring_tx.sv
module spi_ring_tx #(
    parameter int DEPTH  = spi_ring_pkg::RING_DEPTH,
    parameter int DATA_W = spi_ring_pkg::FRAME_W,
    parameter int UCNT_W = spi_ring_pkg::UCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              empty,
    output logic              overflow,
    output logic [UCNT_W-1:0] underflow_cnt,
    input  logic              sclk,
    input  logic              cs_n,
    output logic              miso
);
    localparam int SW = spi_ring_pkg::SYNC_W;

    logic [SW-1:0]     pins_s;
    logic              load;
    logic              bit_out;
    logic [DATA_W-1:0] head;

    spi_ring_sync #(.WIDTH(SW), .RST_VAL(2'b10)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk}),
        .sync_out (pins_s)
    );

    spi_ring_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .UCNT_W(UCNT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (load),
        .head     (head),
        .full     (full),
        .empty    (empty),
        .overflow (overflow),
        .ucnt     (underflow_cnt)
    );

    spi_ring_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[0]),
        .cs_n_s  (pins_s[1]),
        .frame   (head),
        .load    (load),
        .bit_out (bit_out)
    );

    assign miso = cs_n ? 1'bz : bit_out;
endmodule

// File: tb/spi_ring_tx_bench.sv
module spi_ring_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       full, empty, overflow;
    logic [3:0] underflow_cnt;
    wire        miso_w;

    pullup (miso_w);

    spi_ring_tx u_spi_ring_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .empty(empty), .overflow(overflow),
        .underflow_cnt(underflow_cnt), .sclk(sclk), .cs_n(cs_n), .miso(miso_w)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [8];
    int m_rd, m_wr, m_cnt, m_ucnt;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) m_mem[i] = '0;
        m_rd = 0; m_wr = 0; m_cnt = 0; m_ucnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        if (m_cnt < 8) begin
            m_mem[m_wr] = v;
            m_wr = (m_wr + 1) % 8;
            m_cnt++;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic transfer();
        if (m_cnt > 0) begin
            exp_q.push_back(m_mem[m_rd]);
            tag_q.push_back("R3");
            m_rd = (m_rd + 1) % 8;
            m_cnt--;
        end else begin
            exp_q.push_back(m_mem[m_rd]);
            tag_q.push_back(m_mem[m_rd] == 8'h00 ? "R5" : "R4");
            if (m_ucnt < 15) m_ucnt++;
        end
        @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            sclk = 1'b1;
            repeat (10) @(negedge clk);
            sclk = 1'b0;
            repeat (10) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(miso_w == 1'b1, "R8", int'(miso_w), 1);
    endtask

    // Monitor: capture one frame per selection and compare with the scoreboard
    logic [7:0] cap;
    int         nbits;
    bit         in_xfer = 1'b0;

    always @(negedge cs_n) begin
        cap = '0;
        nbits = 0;
        in_xfer = 1'b1;
    end

    always @(posedge sclk) begin
        if (in_xfer) begin
            cap = {cap[6:0], miso_w};
            nbits++;
        end
    end

    always @(posedge cs_n) begin
        if (in_xfer) begin
            in_xfer = 1'b0;
            check(nbits == 8, "R2", nbits, 8);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", int'(cap), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cap == e, t, int'(cap), int'(e));
            end
        end
    end

    task automatic check_flags(input string req);
        @(negedge clk);
        @(negedge clk);
        check(empty == (m_cnt == 0), req, int'(empty), int'(m_cnt == 0));
        check(full == (m_cnt == 8), req, int'(full), int'(m_cnt == 8));
        check(int'(underflow_cnt) == m_ucnt, "R7", int'(underflow_cnt), m_ucnt);
    endtask

    initial begin
        // R9: reset state
        do_reset();
        check(empty == 1'b1, "R9", int'(empty), 1);
        check(full == 1'b0, "R9", int'(full), 0);
        check(overflow == 1'b0, "R9", int'(overflow), 0);
        check(underflow_cnt == 4'd0, "R9", int'(underflow_cnt), 0);
        check(miso_w == 1'b1, "R8", int'(miso_w), 1);

        // No writes: zero frames, then saturation of the counter (R5, R7)
        for (int i = 0; i < 3; i++) transfer();
        check_flags("R1");
        for (int i = 0; i < 14; i++) transfer();
        check(underflow_cnt == 4'd15, "R7", int'(underflow_cnt), 15);

        // Three writes, then five transfers (R3 then R5)
        do_reset();
        host_write(8'hA1); host_write(8'hB2); host_write(8'hC3);
        check_flags("R1");
        for (int i = 0; i < 5; i++) transfer();
        check_flags("R1");

        // Exactly eight writes: full, drain, replay of the slot under the pointer (R1, R4)
        do_reset();
        for (int i = 0; i < 8; i++) host_write(8'h10 + 8'(i * 17));
        check_flags("R1");
        for (int i = 0; i < 10; i++) transfer();
        check_flags("R1");
        host_write(8'h5A); host_write(8'h6B); host_write(8'h7C);
        for (int i = 0; i < 5; i++) transfer();
        check_flags("R4");

        // Eleven writes: three dropped, sticky overflow (R6)
        do_reset();
        for (int i = 0; i < 11; i++) host_write(8'h80 + 8'(i * 5));
        check_flags("R6");
        check(overflow == 1'b1, "R6", int'(overflow), 1);
        for (int i = 0; i < 10; i++) transfer();
        check(overflow == 1'b1, "R6", int'(overflow), 1);
        check_flags("R4");

        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule